// File: doc/BRIEF.md
# Priority-Masked Interrupt Resolver

This block picks winners among 64 interrupt sources. Each source has a pending bit, an enable bit, a fast-type bit and a 4-bit priority. Sources that are pending, enabled and fast-type drive a level-sensitive fast line. Sources that are pending and enabled but not fast-type are normal candidates. They drive a level-sensitive normal line, which a programmable threshold gates. One threshold value turns the gating off.

A surrounding controller holds the pending bits and decodes the register bus. It pulses a claim strobe when software reads the normal or the fast vector. In that same cycle the resolver returns a one-hot mask of the source bit that the holder must clear. At the clock edge it also captures the packed vector word, which the controller returns as read data one cycle later. If a source raises a new request in the same cycle that it is claimed, the new request wins and the clear is suppressed.

Top module: `prio_irq_resolver`

## Requirements
- R1: `fiq` is high exactly when some source is pending, enabled and fast-type.
- R2: A normal candidate is a source that is pending and enabled with its fast-type bit clear. Disabled, idle or fast-type sources never affect `irq` or the normal vector.
- R3: When `nrm_mask` is 31, `irq` is high exactly when a normal candidate exists, whatever the priorities.
- R4: For any `nrm_mask` below 31, `irq` is high exactly when some normal candidate's priority is strictly greater than `nrm_mask`. The priority of source n is `prio_flat[4n+3:4n]`.
- R5: The normal vector word names the normal candidate with the highest priority. Among equal priorities the highest-numbered source wins. The word carries the source number in bits 21:16 and the priority in bits 3:0, with all other bits zero. The word is 32'hFFFFFFFF when there is no candidate.
- R6: The fast vector word is the number of the lowest-numbered fast candidate, zero-extended to 32 bits, or 32'hFFFFFFFF when there is none.
- R7: `nrm_word` and `fst_word` reset to 32'hFFFFFFFF. Each is loaded at the clock edge where its claim strobe is high and holds its value otherwise.
- R8: While a claim strobe is high, `clr_mask` has exactly one bit set, at the source that the claim returns. It is zero when there is no candidate or no strobe.
- R9: A source whose `src_raise` bit is high in the claim cycle is left out of `clr_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pend | input | 64 | Pending bit per source |
| src_en | input | 64 | Enable bit per source |
| src_fast | input | 64 | Fast-type bit per source |
| nrm_mask | input | 5 | Normal-line threshold; 31 disables priority gating |
| prio_flat | input | 256 | Packed 4-bit priorities, source n at bits 4n+3:4n |
| src_raise | input | 64 | New request arriving this cycle, overrides a clear |
| claim_nrm | input | 1 | Normal vector claim strobe |
| claim_fst | input | 1 | Fast vector claim strobe |
| irq | output | 1 | Normal interrupt line |
| fiq | output | 1 | Fast interrupt line |
| nrm_word | output | 32 | Registered normal vector word |
| fst_word | output | 32 | Registered fast vector word |
| clr_mask | output | 64 | One-hot pending-clear request for the claimed source |

## Verification
The bench sweeps every threshold value against random source vectors. On a third of the patterns the priorities are squeezed into a small range, which forces ties. A tree that favoured the lower index on a tie would return the wrong source number. An off-by-one compare (>= instead of >) would raise `irq` at a priority equal to the threshold. A design that gated the open threshold value would drop `irq` for low-priority sources. Further checks cover the empty cases, which must return all ones. A claim with a coincident raise must produce no clear. A vector word must hold between claims; a design that reloaded it every cycle would follow the changing inputs.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int SRC_N    = 64;
    localparam int PRIO_W   = 4;
    localparam int MASK_W   = 5;
    localparam int IDX_W    = $clog2(SRC_N);
    localparam int WORD_W   = 32;
    localparam int SRC_LSB  = 16;
    localparam logic [MASK_W-1:0] OPEN_MASK  = '1;
    localparam logic [WORD_W-1:0] EMPTY_WORD = '1;

    typedef struct packed {
        logic              vld;
        logic [IDX_W-1:0]  idx;
        logic [PRIO_W-1:0] prio;
    } cand_t;

    // Upper (higher-numbered) side wins on equal priority.
    function automatic cand_t pick_hi(cand_t lo, cand_t hi);
        if (hi.vld && (!lo.vld || hi.prio >= lo.prio))
            return hi;
        return lo;
    endfunction

    function automatic logic [WORD_W-1:0] pack_nrm(cand_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        if (!c.vld) return EMPTY_WORD;
        w[SRC_LSB +: IDX_W] = c.idx;
        w[PRIO_W-1:0]       = c.prio;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_fst(cand_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        if (!c.vld) return EMPTY_WORD;
        w[IDX_W-1:0] = c.idx;
        return w;
    endfunction

endpackage

// File: rtl/prio_max_tree.sv
module prio_max_tree
    import prio_irq_pkg::*;
#(
    parameter int N = SRC_N
) (
    input  logic [N-1:0]        cand,
    input  logic [N*PRIO_W-1:0] prio_flat,
    output cand_t               win
);
    // Heap layout: node k has children 2k (lower sources) and 2k+1.
    cand_t node [1:2*N-1];

    for (genvar i = 0; i < N; i++) begin : g_leaf
        assign node[N+i] = '{vld: cand[i], idx: IDX_W'(i),
                             prio: prio_flat[i*PRIO_W +: PRIO_W]};
    end

    for (genvar k = 1; k < N; k++) begin : g_node
        assign node[k] = pick_hi(node[2*k], node[2*k+1]);
    end

    assign win = node[1];
endmodule

// File: rtl/low_first_set.sv
module low_first_set
    import prio_irq_pkg::*;
#(
    parameter int N = SRC_N
) (
    input  logic [N-1:0] bits,
    output cand_t        first
);
    always_comb begin
        first = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits[i]) first.idx = IDX_W'(i);
        end
        first.vld = |bits;
    end
endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver
    import prio_irq_pkg::*;
#(
    parameter int N = SRC_N
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        src_pend,
    input  logic [N-1:0]        src_en,
    input  logic [N-1:0]        src_fast,
    input  logic [MASK_W-1:0]   nrm_mask,
    input  logic [N*PRIO_W-1:0] prio_flat,
    input  logic [N-1:0]        src_raise,
    input  logic                claim_nrm,
    input  logic                claim_fst,
    output logic                irq,
    output logic                fiq,
    output logic [WORD_W-1:0]   nrm_word,
    output logic [WORD_W-1:0]   fst_word,
    output logic [N-1:0]        clr_mask
);
    logic [N-1:0] live, nrm_set, fst_set;
    cand_t        nrm_win, fst_win;
    logic [N-1:0] nrm_hot, fst_hot;

    assign live    = src_pend & src_en;
    assign nrm_set = live & ~src_fast;
    assign fst_set = live & src_fast;

    prio_max_tree #(.N(N)) u_tree (
        .cand      (nrm_set),
        .prio_flat (prio_flat),
        .win       (nrm_win)
    );

    low_first_set #(.N(N)) u_first (
        .bits  (fst_set),
        .first (fst_win)
    );

    // The winner carries the maximum priority, so one compare suffices.
    assign fiq = fst_win.vld;
    assign irq = nrm_win.vld &&
                 ((nrm_mask == OPEN_MASK) || ({1'b0, nrm_win.prio} > nrm_mask));

    always_comb begin
        nrm_hot = '0;
        fst_hot = '0;
        if (claim_nrm && nrm_win.vld) nrm_hot[nrm_win.idx] = 1'b1;
        if (claim_fst && fst_win.vld) fst_hot[fst_win.idx] = 1'b1;
        clr_mask = (nrm_hot | fst_hot) & ~src_raise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nrm_word <= EMPTY_WORD;
            fst_word <= EMPTY_WORD;
        end else begin
            if (claim_nrm) nrm_word <= pack_nrm(nrm_win);
            if (claim_fst) fst_word <= pack_fst(fst_win);
        end
    end
endmodule

// File: rtl/prio_irq_resolver_chk.sv
module prio_irq_resolver_chk
    import prio_irq_pkg::*;
#(
    parameter int N = SRC_N
) (
    input logic              clk,
    input logic              rst,
    input logic [N-1:0]      src_pend,
    input logic [N-1:0]      src_en,
    input logic [N-1:0]      src_fast,
    input logic [MASK_W-1:0] nrm_mask,
    input logic [N-1:0]      src_raise,
    input logic              claim_nrm,
    input logic              claim_fst,
    input logic              irq,
    input logic              fiq,
    input logic [WORD_W-1:0] nrm_word,
    input logic [WORD_W-1:0] fst_word,
    input logic [N-1:0]      clr_mask
);
    p_open_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (nrm_mask == OPEN_MASK && |(src_pend & src_en & ~src_fast)) |-> irq);

    p_no_normal_r2: assert property (@(posedge clk) disable iff (rst)
        !(|(src_pend & src_en & ~src_fast)) |-> !irq);

    p_fst_empty_r6: assert property (@(posedge clk) disable iff (rst)
        (claim_fst && !fiq) |=> fst_word == EMPTY_WORD);

    p_fst_clear_r1: assert property (@(posedge clk) disable iff (rst)
        (claim_fst && !claim_nrm && fiq && src_raise == '0) |-> $countones(clr_mask) == 1);

    p_hold_nrm_r7: assert property (@(posedge clk) disable iff (rst)
        !claim_nrm |=> $stable(nrm_word));

    p_hold_fst_r7: assert property (@(posedge clk) disable iff (rst)
        !claim_fst |=> $stable(fst_word));

    p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        !(claim_nrm && claim_fst) |-> $onehot0(clr_mask));

    p_idle_clr_r8: assert property (@(posedge clk) disable iff (rst)
        !(claim_nrm || claim_fst) |-> clr_mask == '0);

    p_raise_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (clr_mask & src_raise) == '0);
endmodule

bind prio_irq_resolver prio_irq_resolver_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_pend  (src_pend),
    .src_en    (src_en),
    .src_fast  (src_fast),
    .nrm_mask  (nrm_mask),
    .src_raise (src_raise),
    .claim_nrm (claim_nrm),
    .claim_fst (claim_fst),
    .irq       (irq),
    .fiq       (fiq),
    .nrm_word  (nrm_word),
    .fst_word  (fst_word),
    .clr_mask  (clr_mask)
);

// File: tb/tb_prio_irq_resolver.sv
module tb_prio_irq_resolver;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [63:0]  pend = '0, en = '0, fast = '0, raise = '0;
    logic [4:0]   mask = 5'd31;
    logic [255:0] prio = '0;
    logic         c_nrm = 1'b0, c_fst = 1'b0;
    logic         irq, fiq;
    logic [31:0]  nrm_word, fst_word;
    logic [63:0]  clr_mask;
    int total = 0, bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    prio_irq_resolver dut (
        .clk(clk), .rst(rst), .src_pend(pend), .src_en(en), .src_fast(fast),
        .nrm_mask(mask), .prio_flat(prio), .src_raise(raise),
        .claim_nrm(c_nrm), .claim_fst(c_fst), .irq(irq), .fiq(fiq),
        .nrm_word(nrm_word), .fst_word(fst_word), .clr_mask(clr_mask));

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference: scan upward, >= keeps the later (higher) source on ties.
    function automatic int best_src();
        int b = -1;
        for (int i = 0; i < 64; i++)
            if (pend[i] && en[i] && !fast[i])
                if (b < 0 || prio[4*i +: 4] >= prio[4*b +: 4]) b = i;
        return b;
    endfunction

    function automatic int low_fast();
        for (int i = 0; i < 64; i++)
            if (pend[i] && en[i] && fast[i]) return i;
        return -1;
    endfunction

    function automatic bit exp_irq();
        bit any = 0, hit = 0;
        for (int i = 0; i < 64; i++)
            if (pend[i] && en[i] && !fast[i]) begin
                any = 1;
                if (int'(prio[4*i +: 4]) > int'(mask)) hit = 1;
            end
        return (mask == 5'd31) ? any : hit;
    endfunction

    task automatic run_case(input bit with_raise);
        int b, f;
        logic [31:0] ew, ef, hold_n;
        logic [63:0] ec;
        b = best_src();
        f = low_fast();
        #5;
        chk(irq == exp_irq(), "R4/R3 irq", 64'(irq), 64'(exp_irq()));
        chk(fiq == (f >= 0), "R1 fiq", 64'(fiq), 64'(f >= 0));
        ew = (b < 0) ? 32'hFFFFFFFF : ((32'(b) << 16) | 32'(prio[4*b +: 4]));
        ef = (f < 0) ? 32'hFFFFFFFF : 32'(f);
        // normal claim
        @(negedge clk);
        c_nrm = 1'b1;
        if (with_raise) raise = '1;
        #5;
        ec = (b < 0 || with_raise) ? 64'd0 : (64'd1 << b);
        chk(clr_mask == ec, with_raise ? "R9 raise" : "R8 clr_nrm", clr_mask, ec);
        @(negedge clk);
        c_nrm = 1'b0;
        raise = '0;
        #5;
        chk(nrm_word == ew, "R5 nrm_word", 64'(nrm_word), 64'(ew));
        // fast claim
        @(negedge clk);
        c_fst = 1'b1;
        #5;
        ec = (f < 0) ? 64'd0 : (64'd1 << f);
        chk(clr_mask == ec, "R8 clr_fst", clr_mask, ec);
        @(negedge clk);
        c_fst = 1'b0;
        hold_n = nrm_word;
        pend = ~pend;
        #5;
        chk(fst_word == ef, "R6 fst_word", 64'(fst_word), 64'(ef));
        @(negedge clk);
        #5;
        chk(nrm_word == hold_n && clr_mask == 64'd0, "R7 hold",
            64'(nrm_word), 64'(hold_n));
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        #5;
        chk(nrm_word == 32'hFFFFFFFF, "R7 reset nrm", 64'(nrm_word), 64'hFFFFFFFF);
        chk(fst_word == 32'hFFFFFFFF, "R7 reset fst", 64'(fst_word), 64'hFFFFFFFF);
        rst = 1'b0;
        @(negedge clk);
        // Empty: no candidates at all
        run_case(0);
        // R2: fast-type and disabled sources alone give no irq
        @(negedge clk);
        pend = '1; en = 64'hFFFF_0000_FFFF_0000; fast = en; mask = 5'd31;
        prio = '1;
        run_case(0);
        // R5 tie: sources 3 and 40 both at priority 9
        @(negedge clk);
        pend = (64'd1 << 3) | (64'd1 << 40); en = '1; fast = '0; prio = '0;
        prio[12 +: 4] = 4'd9; prio[160 +: 4] = 4'd9;
        mask = 5'd8;
        run_case(0);
        // R4 boundary: priority equal to threshold blocks
        @(negedge clk);
        mask = 5'd9;
        run_case(0);
        for (int it = 0; it < 200; it++) begin
            @(negedge clk);
            pend = {$urandom, $urandom} & ((it % 4 == 0) ? {$urandom, $urandom} : '1);
            en   = {$urandom, $urandom} | {$urandom, $urandom};
            fast = {$urandom, $urandom} & {$urandom, $urandom};
            mask = 5'(it % 32);
            for (int w = 0; w < 64; w++)
                prio[4*w +: 4] = (it % 3 == 0) ? 4'(5 + $urandom % 3) : 4'($urandom);
            run_case(it % 7 == 3);
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule